// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block watches the request stream into a shared memory and keeps, for each execution context, at most one address reservation taken by a load-reserved read. Every store is handed an allow or deny decision in the cycle it is presented. A conditional store gets a success bit back that goes to its requester. Ordinary stores are always let through. A conditional store goes through only while its own context still holds a reservation on the same granule.

Any store that is let through wipes every reservation on its granule, whichever context holds it. In that same cycle each affected owner other than the writer receives a one-cycle clear-exclusive pulse. A conditional store that is turned down leaves the whole table as it was. Addresses lose their low `GRAN_SHIFT` bits before they are stored or compared, so the reservation size is a parameter. The decision and the pulses are combinational from the request. The table changes on the next rising clock edge.

Top module: `resv_monitor`

## Requirements
- R1: Asynchronous reset (rst_n low) empties the table, so a conditional store issued right after reset fails.
- R2: While req_valid is low, store_allow, cond_ok and clr_excl are all zero and the table is left unchanged, whatever the other request inputs carry.
- R3: Addresses are reduced to their granule (the low GRAN_SHIFT bits are cleared, default 3, which gives an 8-byte granule) before they are stored and before they are compared. Two addresses in the same granule therefore match.
- R4: A reservation is recorded only for a valid request with req_rd=1, req_cond=1, req_from_cache=0 and req_ctx_known=1. Reads never produce store_allow, cond_ok or clr_excl.
- R5: Each context holds at most one reservation. A new load-reserved from the same context replaces the address it held before.
- R6: A store is a valid request with req_wr=1 and req_rd=0. An ordinary store (req_cond=0) always gives store_allow=1.
- R7: A conditional store (req_cond=1) succeeds only when req_ctx_known=1 and the requesting context holds a reservation on the same granule. On success cond_ok=1 and store_allow=1; otherwise both are 0.
- R8: A conditional store that fails removes no reservation and raises no clr_excl bit.
- R9: A store that is allowed removes, from the next cycle on, every reservation on its granule, the requester's own one included.
- R10: In the cycle of an allowed store, clr_excl bit i is 1 exactly when context i's reservation is being removed and i is not the requester. A store with req_ctx_known=0 counts as coming from no context, so every removed owner is notified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ctx | input | CTX_W | Requesting context number |
| req_ctx_known | input | 1 | Request carries a context number |
| req_addr | input | ADDR_W | Physical byte address |
| req_rd | input | 1 | Request is a read |
| req_wr | input | 1 | Request is a write |
| req_cond | input | 1 | Load-reserved / store-conditional flag |
| req_from_cache | input | 1 | Read was forwarded by a cache |
| store_allow | output | 1 | Store may update memory |
| cond_ok | output | 1 | Conditional store succeeded |
| clr_excl | output | NUM_CTX | One-cycle clear-exclusive pulse per context |

## Verification
Several contexts are driven to reserve one shared granule and then a different one. The bench then sends ordinary stores, conditional stores from owners and non-owners, and stores with no context, which separates clearing by address from clearing by owner. The tests also cover a reservation being replaced, neighbouring addresses inside and outside one granule, reads forwarded by a cache, and requests held invalid. These show that only the intended requests touch the table. A long run of mixed requests over a few close addresses is then checked against a behavioural model on every request.

// File: rtl/resv_pkg.sv
package resv_pkg;

  // Request class after decoding
  typedef enum logic [1:0] {
    OP_IDLE       = 2'd0,
    OP_LOAD_RSV   = 2'd1,
    OP_STORE      = 2'd2,
    OP_COND_STORE = 2'd3
  } resv_op_e;

endpackage

// File: rtl/resv_classify.sv
module resv_classify
  import resv_pkg::*;
#(
  parameter int NUM_CTX    = 4,
  parameter int CTX_W      = 2,
  parameter int ADDR_W     = 32,
  parameter int GRAN_SHIFT = 3
) (
  input  logic               req_valid,
  input  logic [CTX_W-1:0]   req_ctx,
  input  logic               req_ctx_known,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_rd,
  input  logic               req_wr,
  input  logic               req_cond,
  input  logic               req_from_cache,
  output resv_op_e           op,
  output logic [ADDR_W-1:0]  key,
  output logic [NUM_CTX-1:0] who
);

  localparam logic [ADDR_W-1:0] GRAN_MASK =
    ~((ADDR_W'(1) << GRAN_SHIFT) - ADDR_W'(1));

  assign key = req_addr & GRAN_MASK;

  always_comb begin
    op = OP_IDLE;
    if (req_valid) begin
      if (req_rd) begin
        if (req_cond && !req_from_cache && req_ctx_known) begin
          op = OP_LOAD_RSV;
        end
      end else if (req_wr) begin
        op = req_cond ? OP_COND_STORE : OP_STORE;
      end
    end
  end

  // One-hot of the requesting context; all zero when no context is carried
  for (genvar i = 0; i < NUM_CTX; i++) begin : g_who
    assign who[i] = req_ctx_known && (req_ctx == CTX_W'(i));
  end

endmodule

// File: rtl/resv_table.sv
module resv_table #(
  parameter int NUM_CTX = 4,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTX-1:0] set_vec,
  input  logic [ADDR_W-1:0]  set_key,
  input  logic [NUM_CTX-1:0] clr_vec,
  input  logic [ADDR_W-1:0]  look_key,
  output logic [NUM_CTX-1:0] hit_vec
);

  logic [NUM_CTX-1:0] vld_q;
  logic [NUM_CTX-1:0] vld_d;
  logic [NUM_CTX-1:0] vld_en;
  logic [ADDR_W-1:0]  key_q [NUM_CTX];

  // Next state: a set wins over a clear (they never coincide in use)
  always_comb begin
    for (int i = 0; i < NUM_CTX; i++) begin
      vld_en[i] = set_vec[i] | clr_vec[i];
      vld_d[i]  = set_vec[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CTX; i++) begin
        if (vld_en[i]) vld_q[i] <= vld_d[i];
      end
    end
  end

  // Address storage carries no reset; it is qualified by vld_q
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CTX; i++) begin
      if (set_vec[i]) key_q[i] <= set_key;
    end
  end

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_cmp
    assign hit_vec[i] = vld_q[i] && (key_q[i] == look_key);
  end

endmodule

// File: rtl/resv_decide.sv
module resv_decide
  import resv_pkg::*;
#(
  parameter int NUM_CTX = 4
) (
  input  resv_op_e           op,
  input  logic [NUM_CTX-1:0] who,
  input  logic [NUM_CTX-1:0] hit_vec,
  output logic               store_allow,
  output logic               cond_ok,
  output logic [NUM_CTX-1:0] set_vec,
  output logic [NUM_CTX-1:0] clr_vec,
  output logic [NUM_CTX-1:0] clr_excl
);

  logic own_hit;

  assign own_hit = |(hit_vec & who);

  always_comb begin
    store_allow = 1'b0;
    cond_ok     = 1'b0;
    set_vec     = '0;
    unique case (op)
      OP_LOAD_RSV:   set_vec = who;
      OP_STORE:      store_allow = 1'b1;
      OP_COND_STORE: begin
        store_allow = own_hit;
        cond_ok     = own_hit;
      end
      default: ;
    endcase
  end

  assign clr_vec  = store_allow ? hit_vec : '0;
  assign clr_excl = clr_vec & ~who;

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int NUM_CTX    = 4,
  parameter int ADDR_W     = 32,
  parameter int GRAN_SHIFT = 3,
  parameter int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [CTX_W-1:0]   req_ctx,
  input  logic               req_ctx_known,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_rd,
  input  logic               req_wr,
  input  logic               req_cond,
  input  logic               req_from_cache,
  output logic               store_allow,
  output logic               cond_ok,
  output logic [NUM_CTX-1:0] clr_excl
);

  resv_op_e           op;
  logic [ADDR_W-1:0]  key;
  logic [NUM_CTX-1:0] who;
  logic [NUM_CTX-1:0] hit_vec;
  logic [NUM_CTX-1:0] set_vec;
  logic [NUM_CTX-1:0] clr_vec;

  resv_classify #(
    .NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .ADDR_W(ADDR_W), .GRAN_SHIFT(GRAN_SHIFT)
  ) u_classify (
    .req_valid(req_valid), .req_ctx(req_ctx), .req_ctx_known(req_ctx_known),
    .req_addr(req_addr), .req_rd(req_rd), .req_wr(req_wr), .req_cond(req_cond),
    .req_from_cache(req_from_cache), .op(op), .key(key), .who(who)
  );

  resv_table #(
    .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .set_key(key),
    .clr_vec(clr_vec), .look_key(key), .hit_vec(hit_vec)
  );

  resv_decide #(
    .NUM_CTX(NUM_CTX)
  ) u_decide (
    .op(op), .who(who), .hit_vec(hit_vec), .store_allow(store_allow),
    .cond_ok(cond_ok), .set_vec(set_vec), .clr_vec(clr_vec), .clr_excl(clr_excl)
  );

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int NUM_CTX    = 4,
  parameter int ADDR_W     = 32,
  parameter int GRAN_SHIFT = 3,
  parameter int CTX_W      = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [CTX_W-1:0]   req_ctx,
  input logic               req_ctx_known,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               req_rd,
  input logic               req_wr,
  input logic               req_cond,
  input logic               req_from_cache,
  input logic               store_allow,
  input logic               cond_ok,
  input logic [NUM_CTX-1:0] clr_excl
);

  localparam logic [ADDR_W-1:0] GMASK =
    ~((ADDR_W'(1) << GRAN_SHIFT) - ADDR_W'(1));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!store_allow && !cond_ok && clr_excl == '0));

  assert_read_no_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_rd) |-> (!store_allow && !cond_ok && clr_excl == '0));

  assert_plain_store_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_wr && !req_rd && !req_cond) |-> store_allow);

  assert_success_allows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cond_ok |-> store_allow);

  assert_deny_no_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !store_allow |-> (clr_excl == '0));

  assert_success_consumed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cond_ok) && req_valid && req_wr && !req_rd && req_cond && req_ctx_known
     && req_ctx == $past(req_ctx)
     && (req_addr & GMASK) == ($past(req_addr) & GMASK)) |-> !cond_ok);

  assert_writer_not_notified_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ctx_known) |-> (((clr_excl >> req_ctx) & NUM_CTX'(1)) == '0));

endmodule

bind resv_monitor resv_monitor_chk #(
  .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .GRAN_SHIFT(GRAN_SHIFT), .CTX_W(CTX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
  .req_ctx_known(req_ctx_known), .req_addr(req_addr), .req_rd(req_rd),
  .req_wr(req_wr), .req_cond(req_cond), .req_from_cache(req_from_cache),
  .store_allow(store_allow), .cond_ok(cond_ok), .clr_excl(clr_excl)
);

// File: tb/resv_monitor_bench.sv
module resv_monitor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCTX = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ctx_known, req_rd, req_wr, req_cond, req_from_cache;
  logic [1:0]  req_ctx;
  logic [31:0] req_addr;
  logic        store_allow, cond_ok;
  logic [3:0]  clr_excl;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reservation model
  bit          mv [NCTX];
  logic [31:0] ma [NCTX];

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_monitor u_resv_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
    .req_ctx_known(req_ctx_known), .req_addr(req_addr), .req_rd(req_rd),
    .req_wr(req_wr), .req_cond(req_cond), .req_from_cache(req_from_cache),
    .store_allow(store_allow), .cond_ok(cond_ok), .clr_excl(clr_excl)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit rd, input bit wr, input bit cnd,
                      input bit fc, input bit known, input logic [1:0] ctx,
                      input logic [31:0] addr, input string tag);
    logic [31:0] m;
    bit ld, st, own, allow, okx;
    logic [3:0] eclr, rm;
    @(negedge clk);
    req_valid = v; req_rd = rd; req_wr = wr; req_cond = cnd;
    req_from_cache = fc; req_ctx_known = known; req_ctx = ctx; req_addr = addr;
    #1;
    m     = addr & 32'hFFFF_FFF8;
    ld    = v && rd && cnd && !fc && known;
    st    = v && wr && !rd;
    own   = st && cnd && known && mv[ctx] && (ma[ctx] == m);
    allow = st && (!cnd || own);
    okx   = own;
    eclr  = '0;
    rm    = '0;
    if (allow) begin
      for (int i = 0; i < NCTX; i++) begin
        if (mv[i] && ma[i] == m) begin
          rm[i] = 1'b1;
          if (!(known && ctx == 2'(i))) eclr[i] = 1'b1;
        end
      end
    end
    check(store_allow == allow, tag, "store_allow", 32'(store_allow), 32'(allow));
    check(cond_ok == okx,       tag, "cond_ok",     32'(cond_ok),     32'(okx));
    check(clr_excl == eclr,     tag, "clr_excl",    32'(clr_excl),    32'(eclr));
    @(posedge clk);
    #1;
    for (int i = 0; i < NCTX; i++) if (rm[i]) mv[i] = 1'b0;
    if (ld) begin mv[ctx] = 1'b1; ma[ctx] = m; end
  endtask

  task automatic lr(input logic [1:0] c, input logic [31:0] a, input string t);
    step(1, 1, 0, 1, 0, 1, c, a, t);
  endtask
  task automatic sc(input logic [1:0] c, input logic [31:0] a, input string t);
    step(1, 0, 1, 1, 0, 1, c, a, t);
  endtask
  task automatic st(input logic [1:0] c, input logic [31:0] a, input string t);
    step(1, 0, 1, 0, 0, 1, c, a, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCTX; i++) begin mv[i] = 0; ma[i] = '0; end
    rst_n = 1'b0;
    req_valid = 0; req_rd = 0; req_wr = 0; req_cond = 0; req_from_cache = 0;
    req_ctx_known = 0; req_ctx = '0; req_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    check(store_allow == 0 && cond_ok == 0 && clr_excl == 0, "R1", "reset outputs",
          {30'd0, store_allow, cond_ok}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1: nothing reserved after reset
    sc(0, 32'h100, "R1");
    // R7/R9: success then consumed
    lr(0, 32'h100, "R4");
    sc(0, 32'h100, "R7");
    sc(0, 32'h100, "R9");
    // R4: plain read and cached read make no reservation
    step(1, 1, 0, 0, 0, 1, 1, 32'h200, "R4");
    sc(1, 32'h200, "R4");
    step(1, 1, 0, 1, 1, 1, 2, 32'h200, "R4");
    sc(2, 32'h200, "R4");
    // R5: replacement
    lr(0, 32'h300, "R5");
    lr(0, 32'h340, "R5");
    sc(0, 32'h300, "R5");
    sc(0, 32'h340, "R5");
    // R3: granule matching
    lr(1, 32'h401, "R3");
    sc(1, 32'h405, "R3");
    lr(1, 32'h401, "R3");
    sc(1, 32'h409, "R3");
    sc(1, 32'h407, "R3");
    // R6/R10: plain store clears sharers, notifies others
    lr(0, 32'h500, "R10");
    lr(1, 32'h504, "R10");
    lr(2, 32'h600, "R10");
    st(3, 32'h500, "R6");
    sc(0, 32'h500, "R9");
    sc(2, 32'h600, "R9");
    // R8: failed conditional store disturbs nothing
    lr(0, 32'h700, "R8");
    lr(1, 32'h700, "R8");
    sc(0, 32'h780, "R8");
    sc(2, 32'h700, "R8");
    sc(1, 32'h700, "R10");
    sc(0, 32'h700, "R9");
    // R10: store with no context notifies every owner
    lr(0, 32'h800, "R10");
    lr(3, 32'h800, "R10");
    step(1, 0, 1, 0, 0, 0, 0, 32'h800, "R10");
    step(1, 0, 1, 1, 0, 0, 0, 32'h800, "R7");
    // R2: invalid request ignored, reservation survives
    lr(2, 32'h900, "R2");
    step(0, 0, 1, 0, 0, 1, 3, 32'h900, "R2");
    step(0, 1, 0, 1, 0, 1, 2, 32'hA00, "R2");
    sc(2, 32'h900, "R2");

    // Mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      int k;
      a = 32'h1000 + 32'($urandom_range(0, 3) * 8) + 32'($urandom_range(0, 7));
      k = $urandom_range(0, 9);
      step(k != 9, k < 4, k >= 4, (k < 3) || (k >= 6), k == 2,
           $urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)), a, "R7");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule